// File: doc/BRIEF.md
# Serial Channel Receive Queue with Local Loopback

This block is the receive half of one channel of a byte-oriented serial controller. Bytes arrive from an external deserializer, or, when local loopback is selected, from host writes to the transmit holding register. Accepted bytes go into a small circular queue. The block keeps a data-ready flag, a queue-full flag and a level receive interrupt status. It also raises a one-cycle interrupt pulse each time a byte is stored, and again after each host read that leaves data behind, so an edge-driven interrupt controller keeps draining the queue.

The host uses a byte-wide register bus with four addresses. Address 0 reaches two mode registers through a pointer that moves from the first to the second after one write. Address 1 is a command register when written and a status register when read. Address 2 is the transmit holding register when written and the receive holding register when read. Address 3 reads as zero and ignores writes.

Top module: `sio_rx_channel`

## Requirements
- R1: After a system reset (rst_n low), rx_ready, rx_full, rx_irq, rx_irq_pulse and tx_load are 0, tx_data, mode1 and mode2 are 0, the receiver is disabled and the mode pointer selects mode1.
- R2: A write to address 1 is a command: bits[1:0]=2'b01 enables the receiver, 2'b10 disables it, and the other codes leave it alone. Bit 4 set clears both queue pointers, rx_ready, rx_full, rx_irq and rx_irq_pulse, and returns the mode pointer to mode1. The enable state is kept.
- R3: With the receiver enabled, loopback off and the queue not full, a des_valid cycle with des_break low stores des_data. In the next cycle rx_ready, rx_irq and a one-cycle rx_irq_pulse are high.
- R4: A des_valid cycle with des_break high stores nothing.
- R5: While the receiver is disabled, no byte is stored from either source.
- R6: Once DEPTH bytes are held, rx_full is 1, later bytes are dropped and the stored bytes are kept unchanged.
- R7: A read of address 2 with rx_ready high returns the oldest byte and removes it, so bytes leave in arrival order. Any such read clears rx_full.
- R8: A read that leaves bytes in the queue gives a one-cycle rx_irq_pulse and keeps rx_ready and rx_irq high. A read that empties the queue clears rx_ready, rx_full and rx_irq.
- R9: A read of address 2 while rx_ready is low changes no pointer and no flag.
- R10: Loopback is active when mode1[7:6]=2'b10. In loopback, a write to address 2 loads tx_data, does not pulse tx_load and stores the byte in the queue under R5 and R6, and deserializer input is ignored. Outside loopback, the write loads tx_data and pulses tx_load for one cycle, and it stores nothing.
- R11: A write to address 0 goes to mode1 when the pointer selects mode1 and then moves the pointer to mode2. Later writes go to mode2. A read of address 0 returns the selected register.
- R12: A read of address 1 returns status: bit0 rx_ready, bit1 rx_full, bit2 receiver enabled, bit3 loopback active, bit4 mode pointer (1 = mode2), other bits 0. A read of address 3 returns 0.
- R13: A store and a read in the same cycle both take effect, and order is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational during a read |
| des_valid | input | 1 | Deserializer has a character this cycle |
| des_break | input | 1 | The character is a break condition |
| des_data | input | 8 | Deserialized byte |
| tx_data | output | 8 | Transmit holding register |
| tx_load | output | 1 | One-cycle pulse: tx_data is ready for the serializer |
| mode1 | output | 8 | First mode register |
| mode2 | output | 8 | Second mode register |
| rx_ready | output | 1 | Queue holds at least one byte |
| rx_full | output | 1 | Queue holds DEPTH bytes |
| rx_irq | output | 1 | Level receive interrupt status |
| rx_irq_pulse | output | 1 | One-cycle receive interrupt request |

## Verification
The assertions assume that bus_sel lasts one cycle per access and that a command write, a mode write and a data write never fall in the same cycle. They also assume that mode1 changes only through bus writes, so the loopback selection seen in a cycle is the one the ingress logic used. The bench keeps to this by issuing every bus access through a single task that holds the strobe for exactly one clock. Deserializer characters are driven from their own task, and these overlap a host read in only one planned case, which tests R13.

// File: rtl/sio_rx_pkg.sv
// Shared definitions for the serial receive channel.
// Assumes an 8-bit character path and a 2-bit register address.
package sio_rx_pkg;

    localparam int CHAR_W   = 8;
    localparam int ADDR_W   = 2;

    // Register map of the channel
    typedef enum logic [ADDR_W-1:0] {
        REG_MODE  = 2'd0,
        REG_CTRL  = 2'd1,
        REG_DATA  = 2'd2,
        REG_SPARE = 2'd3
    } reg_addr_e;

    // Receiver enable command field, bits [1:0] of a control write
    typedef enum logic [1:0] {
        CMD_NOP    = 2'b00,
        CMD_RX_ON  = 2'b01,
        CMD_RX_OFF = 2'b10,
        CMD_HOLD   = 2'b11
    } rx_cmd_e;

    localparam int          CMD_CLR_BIT = 4;      // reset-receiver command bit
    localparam logic [1:0]  LOOP_CODE   = 2'b10;  // mode1[7:6] value for loopback

    // Status byte layout
    localparam int ST_READY = 0;
    localparam int ST_FULL  = 1;
    localparam int ST_EN    = 2;
    localparam int ST_LOOP  = 3;
    localparam int ST_MSEL  = 4;

    // One candidate character for the queue
    typedef struct packed {
        logic              push;
        logic [CHAR_W-1:0] data;
    } rx_push_t;

endpackage

// File: rtl/sio_mode_regs.sv
// Two mode registers reached through one address.
// The pointer selects mode1 after reset, moves to mode2 after the first
// write and stays there until clr_ptr. Assumes wr_en and clr_ptr are never
// high together; clr_ptr wins if they are.
module sio_mode_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         clr_ptr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mode1,
    output logic [W-1:0] mode2,
    output logic         sel,
    output logic [W-1:0] rd_val
);

    // Mode storage and auto-advancing pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode1 <= '0;
            mode2 <= '0;
            sel   <= 1'b0;
        end else if (clr_ptr) begin
            sel   <= 1'b0;
        end else if (wr_en) begin
            if (sel) mode2 <= wdata;
            else     mode1 <= wdata;
            sel <= 1'b1;
        end
    end

    // Read view of the register the pointer selects
    always_comb rd_val = sel ? mode2 : mode1;

endmodule

// File: rtl/sio_rx_ingress.sv
// Picks the source of the next character and decides whether it is stored.
// In loopback only host transmit writes count. Otherwise deserializer
// characters count, except break conditions. Nothing is stored while the
// receiver is disabled or the queue is full. Purely combinational.
module sio_rx_ingress
    import sio_rx_pkg::*;
(
    input  logic              loop_en,
    input  logic              rx_en,
    input  logic              q_full,
    input  logic              des_valid,
    input  logic              des_break,
    input  logic [CHAR_W-1:0] des_data,
    input  logic              host_tx_wr,
    input  logic [CHAR_W-1:0] host_wdata,
    output rx_push_t          cand
);

    logic src_valid;

    // Source selection: loopback takes host bytes, normal takes the line
    always_comb begin
        if (loop_en) begin
            src_valid = host_tx_wr;
            cand.data = host_wdata;
        end else begin
            src_valid = des_valid && !des_break;
            cand.data = des_data;
        end
    end

    // Admission: receiver on and room left
    always_comb cand.push = src_valid && rx_en && !q_full;

endmodule

// File: rtl/sio_rx_fifo.sv
// Circular receive queue with ready/full/interrupt flags.
// Pointers wrap at DEPTH (any DEPTH >= 2). Equal pointers mean empty unless
// full is set. A pop is honoured only while ready is high. Assumes the
// caller never pushes while full.
module sio_rx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop_req,
    output logic [W-1:0] head,
    output logic         ready,
    output logic         full,
    output logic         irq,
    output logic         irq_pulse
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr, wnext, rnext;
    logic             pop;

    // Advance a pointer with wrap at the last entry
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        wnext = bump(wptr);
        rnext = bump(rptr);
        pop   = pop_req && ready;
        head  = mem[rptr];
    end

    // One write-enabled storage entry per slot
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                                  mem[i] <= '0;
            else if (push && (wptr == PTR_W'(i)))        mem[i] <= push_data;
        end
    end

    // Pointer and flag update for push, pop or both
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr      <= '0;
            rptr      <= '0;
            ready     <= 1'b0;
            full      <= 1'b0;
            irq       <= 1'b0;
            irq_pulse <= 1'b0;
        end else begin
            if (push) wptr <= wnext;
            if (pop)  rptr <= rnext;
            unique case ({push, pop})
                2'b10: begin
                    ready     <= 1'b1;
                    irq       <= 1'b1;
                    irq_pulse <= 1'b1;
                    full      <= (wnext == rptr);
                end
                2'b01: begin
                    full <= 1'b0;
                    if (rnext == wptr) begin
                        ready     <= 1'b0;
                        irq       <= 1'b0;
                        irq_pulse <= 1'b0;
                    end else begin
                        irq_pulse <= 1'b1;
                    end
                end
                2'b11: begin
                    ready     <= 1'b1;
                    irq       <= 1'b1;
                    irq_pulse <= 1'b1;
                    full      <= 1'b0;
                end
                default: irq_pulse <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/sio_rx_channel.sv
// Receive side of one serial channel: register decode, receiver enable,
// transmit holding latch, mode registers, ingress selection and the queue.
// Assumes one bus access per bus_sel cycle; read data is combinational.
module sio_rx_channel
    import sio_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CHAR_W-1:0] bus_wdata,
    output logic [CHAR_W-1:0] bus_rdata,
    input  logic              des_valid,
    input  logic              des_break,
    input  logic [CHAR_W-1:0] des_data,
    output logic [CHAR_W-1:0] tx_data,
    output logic              tx_load,
    output logic [CHAR_W-1:0] mode1,
    output logic [CHAR_W-1:0] mode2,
    output logic              rx_ready,
    output logic              rx_full,
    output logic              rx_irq,
    output logic              rx_irq_pulse
);

    logic              mode_wr, ctrl_wr, data_wr, data_rd, bus_rd;
    logic              rx_clr, rx_en, loop_en, mode_sel;
    logic [CHAR_W-1:0] mode_rd, head, status;
    rx_push_t          cand;

    // Address decode of the single-cycle access
    always_comb begin
        bus_rd  = bus_sel && !bus_wr;
        mode_wr = bus_sel && bus_wr && (bus_addr == REG_MODE);
        ctrl_wr = bus_sel && bus_wr && (bus_addr == REG_CTRL);
        data_wr = bus_sel && bus_wr && (bus_addr == REG_DATA);
        data_rd = bus_rd && (bus_addr == REG_DATA);
        rx_clr  = ctrl_wr && bus_wdata[CMD_CLR_BIT];
        loop_en = (mode1[7:6] == LOOP_CODE);
    end

    // Receiver enable from the command field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en <= 1'b0;
        end else if (ctrl_wr) begin
            unique case (rx_cmd_e'(bus_wdata[1:0]))
                CMD_RX_ON:  rx_en <= 1'b1;
                CMD_RX_OFF: rx_en <= 1'b0;
                default:    rx_en <= rx_en;
            endcase
        end
    end

    // Transmit holding latch and serializer load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data <= '0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= data_wr && !loop_en;
            if (data_wr) tx_data <= bus_wdata;
        end
    end

    sio_mode_regs #(.W(CHAR_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr),
        .clr_ptr (rx_clr),
        .wdata   (bus_wdata),
        .mode1   (mode1),
        .mode2   (mode2),
        .sel     (mode_sel),
        .rd_val  (mode_rd)
    );

    sio_rx_ingress u_ing (
        .loop_en    (loop_en),
        .rx_en      (rx_en),
        .q_full     (rx_full),
        .des_valid  (des_valid),
        .des_break  (des_break),
        .des_data   (des_data),
        .host_tx_wr (data_wr),
        .host_wdata (bus_wdata),
        .cand       (cand)
    );

    sio_rx_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rx_clr),
        .push      (cand.push),
        .push_data (cand.data),
        .pop_req   (data_rd),
        .head      (head),
        .ready     (rx_ready),
        .full      (rx_full),
        .irq       (rx_irq),
        .irq_pulse (rx_irq_pulse)
    );

    // Status byte assembly
    always_comb begin
        status           = '0;
        status[ST_READY] = rx_ready;
        status[ST_FULL]  = rx_full;
        status[ST_EN]    = rx_en;
        status[ST_LOOP]  = loop_en;
        status[ST_MSEL]  = mode_sel;
    end

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (reg_addr_e'(bus_addr))
                REG_MODE: bus_rdata = mode_rd;
                REG_CTRL: bus_rdata = status;
                REG_DATA: bus_rdata = head;
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sio_rx_channel_chk.sv
// Property checker for sio_rx_channel, attached by bind below.
// Assumes one access per bus_sel cycle and mode1 changing only by bus writes.
module sio_rx_channel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       des_valid,
    input logic       des_break,
    input logic [7:0] mode1,
    input logic       mode_sel,
    input logic       rx_ready,
    input logic       rx_full,
    input logic       rx_irq,
    input logic       rx_irq_pulse,
    input logic       tx_load
);

    a_r6_full_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> rx_ready);

    a_r8_irq_follows_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq == rx_ready);

    a_r8_pulse_only_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq_pulse |-> rx_ready);

    a_r3_ready_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past((des_valid && !des_break && mode1[7:6] != 2'b10) ||
                                  (bus_sel && bus_wr && bus_addr == 2'd2 && mode1[7:6] == 2'b10)));

    a_r4_break_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (des_valid && des_break && !rx_ready && !bus_sel) |=> !rx_ready);

    a_r10_no_load_in_loop: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> $past(mode1[7:6] != 2'b10));

    a_r11_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && !(bus_sel && bus_wr && bus_addr == 2'd1 && bus_wdata[4])) |=> mode_sel);

endmodule

bind sio_rx_channel sio_rx_channel_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .des_valid    (des_valid),
    .des_break    (des_break),
    .mode1        (mode1),
    .mode_sel     (mode_sel),
    .rx_ready     (rx_ready),
    .rx_full      (rx_full),
    .rx_irq       (rx_irq),
    .rx_irq_pulse (rx_irq_pulse),
    .tx_load      (tx_load)
);

// File: tb/sio_rx_channel_tb.sv
`timescale 1ns/1ps
module sio_rx_channel_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       des_valid = 1'b0, des_break = 1'b0;
    logic [7:0] des_data = '0;
    logic [7:0] tx_data, mode1, mode2;
    logic       tx_load, rx_ready, rx_full, rx_irq, rx_irq_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sio_rx_channel #(.DEPTH(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .des_valid(des_valid), .des_break(des_break), .des_data(des_data),
        .tx_data(tx_data), .tx_load(tx_load), .mode1(mode1), .mode2(mode2),
        .rx_ready(rx_ready), .rx_full(rx_full), .rx_irq(rx_irq),
        .rx_irq_pulse(rx_irq_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One write; returns at the negedge after the capturing edge
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // One read; data sampled before the capturing edge
    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic des_send(input logic [7:0] d, input logic brk);
        @(negedge clk);
        des_valid = 1'b1; des_data = d; des_break = brk;
        @(negedge clk);
        des_valid = 1'b0; des_break = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 ready", rx_ready, 0);
        check("R1 full/irq/pulse/load", {rx_full, rx_irq, rx_irq_pulse, tx_load}, 0);
        check("R1 regs", {tx_data, mode1, mode2}, 0);
        bus_read(2'd1, v);
        check("R1 status", v, 8'h00);
    endtask

    task automatic t_disabled();
        des_send(8'h11, 1'b0);
        check("R5 disabled drop", rx_ready, 0);
        bus_write(2'd1, 8'h01);
    endtask

    task automatic t_basic();
        logic [7:0] v;
        bus_read(2'd1, v);
        check("R2 enable status", v, 8'h04);
        des_send(8'hA5, 1'b0);
        check("R3 ready/irq/pulse", {rx_ready, rx_irq, rx_irq_pulse}, 3'b111);
        @(negedge clk);
        check("R3 pulse one cycle", rx_irq_pulse, 0);
        des_send(8'h3C, 1'b0);
        bus_read(2'd2, v);
        check("R7 oldest first", v, 8'hA5);
        check("R8 repulse keeps ready", {rx_irq_pulse, rx_ready, rx_irq}, 3'b111);
        bus_read(2'd2, v);
        check("R7 second", v, 8'h3C);
        check("R8 empty clears", {rx_ready, rx_irq, rx_irq_pulse}, 3'b000);
    endtask

    task automatic t_break();
        des_send(8'h77, 1'b1);
        check("R4 break dropped", rx_ready, 0);
    endtask

    task automatic t_full();
        logic [7:0] v;
        for (int i = 0; i < 4; i++) des_send(8'h10 + 8'(i), 1'b0);
        check("R6 full", rx_full, 1);
        bus_read(2'd1, v);
        check("R12 status full", v, 8'h07);
        des_send(8'h99, 1'b0);
        for (int i = 0; i < 4; i++) begin
            bus_read(2'd2, v);
            check("R6 content kept", v, 8'h10 + 8'(i));
            if (i == 0) check("R7 full cleared", rx_full, 0);
        end
        check("R6 overflow byte dropped", rx_ready, 0);
    endtask

    task automatic t_empty_read();
        logic [7:0] v;
        bus_read(2'd2, v);
        check("R9 empty read no change", {rx_ready, rx_full, rx_irq_pulse}, 0);
        des_send(8'h42, 1'b0);
        bus_read(2'd2, v);
        check("R9 pointer not moved", v, 8'h42);
    endtask

    task automatic t_simul();
        logic [7:0] v;
        des_send(8'h50, 1'b0);
        @(negedge clk);
        des_valid = 1'b1; des_data = 8'h51;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd2;
        #1 v = bus_rdata;
        @(negedge clk);
        des_valid = 1'b0; bus_sel = 1'b0;
        check("R13 read during push", v, 8'h50);
        check("R13 still ready", rx_ready, 1);
        bus_read(2'd2, v);
        check("R13 pushed byte", v, 8'h51);
        check("R13 empty", rx_ready, 0);
    endtask

    task automatic t_mode();
        logic [7:0] v;
        bus_write(2'd0, 8'h80);
        check("R11 mode1 first", mode1, 8'h80);
        bus_write(2'd0, 8'h17);
        bus_write(2'd0, 8'h29);
        check("R11 mode2 sticks", {mode1, mode2}, 16'h8029);
        bus_read(2'd0, v);
        check("R11 read mode2", v, 8'h29);
        bus_read(2'd1, v);
        check("R12 status loop+ptr", v, 8'h1C);
        bus_write(2'd1, 8'h10);
        bus_read(2'd0, v);
        check("R11 ptr back to mode1", v, 8'h80);
        bus_read(2'd3, v);
        check("R12 spare reads zero", v, 8'h00);
    endtask

    task automatic t_loop();
        logic [7:0] v;
        des_send(8'h66, 1'b0);
        check("R10 line ignored in loop", rx_ready, 0);
        bus_write(2'd2, 8'hC3);
        check("R10 loop tx_data/no load", {tx_data, tx_load}, {8'hC3, 1'b0});
        check("R10 loop stored", rx_ready, 1);
        bus_read(2'd2, v);
        check("R10 loop byte", v, 8'hC3);
        bus_write(2'd0, 8'h00);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h5A;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R10 normal load pulse", {tx_data, tx_load}, {8'h5A, 1'b1});
        check("R10 normal no store", rx_ready, 0);
        @(negedge clk);
        check("R10 load one cycle", tx_load, 0);
    endtask

    task automatic t_cmd();
        logic [7:0] v;
        des_send(8'h01, 1'b0);
        des_send(8'h02, 1'b0);
        bus_write(2'd1, 8'h10);
        check("R2 clear cmd", {rx_ready, rx_full, rx_irq}, 0);
        des_send(8'h21, 1'b0);
        bus_read(2'd2, v);
        check("R2 pointers zeroed, enable kept", v, 8'h21);
        bus_write(2'd1, 8'h02);
        bus_read(2'd1, v);
        check("R2 disable status", v, 8'h00);
        des_send(8'h33, 1'b0);
        check("R5 disabled after cmd", rx_ready, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_basic();
        t_break();
        t_full();
        t_empty_read();
        t_simul();
        t_mode();
        t_loop();
        t_cmd();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule